// File: doc/BRIEF.md
# Banked ROM/RAM Address Decoder

This block watches the 16-bit address bus of an 8-bit processor and steers each access to one of two external memories: a 512 KB ROM, seen as eight 64 KB banks, and a 32 KB SRAM. A 3-bit bank number picks the ROM bank. The block passes that number straight out as the three upper ROM address lines. The CPU address supplies the lower sixteen lines.

Each bank also sets where the SRAM appears in the CPU space, and the SRAM wins over ROM wherever the two overlap. The low four banks get a 32 KB window starting at $2000. The next two banks get a 24 KB window at the same base. The top two banks get only an 8 KB window at $A000. Nothing below $2000 is ever claimed. Every output is active-low and purely combinational from the address, read/write, access strobe and bank inputs.

Top module: `bdec_top`

## Requirements
- R1: An address below $2000 drives rom_ce_n, ram_ce_n, mem_oe_n and ram_we_n high, for any bank and any access.
- R2: With bank 0 to 3, $2000 to $9FFF selects SRAM (ram_ce_n low). A read at $A000 or above selects ROM (rom_ce_n low).
- R3: With bank 4 or 5, $2000 to $7FFF selects SRAM. A read at $8000 or above selects ROM.
- R4: With bank 6 or 7, only $A000 to $BFFF selects SRAM. A read at $2000 to $9FFF, or at $C000 and above, selects ROM.
- R5: rom_ce_n and ram_ce_n are never low at the same time.
- R6: rom_hi always equals bank_sel, with bit 0 of rom_hi being bit 0 of the bank number.
- R7: While SRAM is selected, ram_addr equals the CPU address minus the window base ($2000 or $A000), truncated to 15 bits.
- R8: A write (cpu_rnw low) to an address that only ROM would serve leaves every enable high.
- R9: ram_we_n is low only when SRAM is selected, cpu_rnw is low and acc_strobe is high.
- R10: mem_oe_n is low only on a read (cpu_rnw high) with acc_strobe high while ROM or SRAM is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | CPU address bus |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| acc_strobe | input | 1 | Clock-qualified access strobe, active high |
| bank_sel | input | 3 | Current ROM bank number |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_hi | output | 3 | ROM address bits 18 to 16 |
| ram_ce_n | output | 1 | SRAM chip enable, active low |
| ram_addr | output | 15 | SRAM address |
| mem_oe_n | output | 1 | Shared output enable, active low |
| ram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bench builds the decoder with its default parameters: floor at $2000, window limits at $A000, $8000 and $C000, the narrow window starting at bank 4 and the high window at bank 6. With these values all eight banks, and so all three window shapes, can be driven. A sweep then walks every bank across each window edge, one address below and one at the edge. This shows where priority passes from SRAM to ROM. The table vectors add writes and strobe-low cycles, so the gating of the write and output enables is covered.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

    localparam int unsigned CPU_AW = 16;
    localparam int unsigned BANK_W = 3;
    localparam int unsigned RAM_AW = 15;
    localparam int unsigned N_KINDS = 3;

    typedef enum logic [1:0] {
        WIN_WIDE   = 2'd0,
        WIN_NARROW = 2'd1,
        WIN_HIGH   = 2'd2
    } window_kind_e;

    typedef struct packed {
        logic rom;
        logic ram;
    } dev_sel_t;

    function automatic window_kind_e kind_of(input logic [BANK_W-1:0] b,
                                             input int narrow_first,
                                             input int high_first);
        if (int'(b) >= high_first)
            return WIN_HIGH;
        else if (int'(b) >= narrow_first)
            return WIN_NARROW;
        return WIN_WIDE;
    endfunction

endpackage

// File: rtl/bdec_window.sv
module bdec_window
    import bdec_pkg::*;
#(
    parameter logic [CPU_AW-1:0] ROM_FLOOR  = 16'h2000,
    parameter logic [CPU_AW-1:0] WIDE_END   = 16'hA000,
    parameter logic [CPU_AW-1:0] NARROW_END = 16'h8000,
    parameter logic [CPU_AW-1:0] HIGH_BASE  = 16'hA000,
    parameter logic [CPU_AW-1:0] HIGH_END   = 16'hC000,
    parameter int NARROW_FIRST = 4,
    parameter int HIGH_FIRST   = 6
) (
    input  logic [CPU_AW-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    output logic              ram_hit,
    output logic [RAM_AW-1:0] ram_off
);

    localparam logic [CPU_AW-1:0] BASES  [N_KINDS] = '{ROM_FLOOR, ROM_FLOOR, HIGH_BASE};
    localparam logic [CPU_AW-1:0] LIMITS [N_KINDS] = '{WIDE_END, NARROW_END, HIGH_END};

    logic              in_rng [N_KINDS];
    logic [CPU_AW-1:0] diff   [N_KINDS];
    window_kind_e      kind;

    for (genvar k = 0; k < N_KINDS; k++) begin : g_kind
        assign in_rng[k] = (addr >= BASES[k]) && (addr < LIMITS[k]);
        assign diff[k]   = addr - BASES[k];
    end

    always_comb begin
        kind    = kind_of(bank, NARROW_FIRST, HIGH_FIRST);
        ram_hit = 1'b0;
        ram_off = '0;
        for (int k = 0; k < N_KINDS; k++) begin
            if (k == int'(kind)) begin
                ram_hit = in_rng[k];
                ram_off = diff[k][RAM_AW-1:0];
            end
        end
    end

endmodule

// File: rtl/bdec_rom_map.sv
module bdec_rom_map
    import bdec_pkg::*;
#(
    parameter logic [CPU_AW-1:0] ROM_FLOOR = 16'h2000
) (
    input  logic [CPU_AW-1:0] addr,
    input  logic              rnw,
    input  logic              ram_hit,
    input  logic [BANK_W-1:0] bank,
    output logic              rom_sel,
    output logic [BANK_W-1:0] rom_hi
);

    always_comb begin
        rom_sel = (addr >= ROM_FLOOR) && !ram_hit && rnw;
        rom_hi  = bank;
    end

endmodule

// File: rtl/bdec_strobe.sv
module bdec_strobe
    import bdec_pkg::*;
(
    input  logic     rnw,
    input  logic     stb,
    input  dev_sel_t sel,
    output logic     rom_ce_n,
    output logic     ram_ce_n,
    output logic     oe_n,
    output logic     we_n
);

    always_comb begin
        rom_ce_n = !sel.rom;
        ram_ce_n = !sel.ram;
        oe_n     = !((sel.rom || sel.ram) && rnw && stb);
        we_n     = !(sel.ram && !rnw && stb);
    end

    always_comb begin
        if (!$isunknown({we_n, oe_n, ram_ce_n})) begin
            assert_we_needs_ram_R9 : assert (we_n || !ram_ce_n)
                else $error("write enable without SRAM select");
            assert_oe_we_excl_R10 : assert (we_n || oe_n)
                else $error("output and write enable both active");
        end
    end

endmodule

// File: rtl/bdec_top.sv
module bdec_top
    import bdec_pkg::*;
#(
    parameter logic [CPU_AW-1:0] ROM_FLOOR  = 16'h2000,
    parameter logic [CPU_AW-1:0] WIDE_END   = 16'hA000,
    parameter logic [CPU_AW-1:0] NARROW_END = 16'h8000,
    parameter logic [CPU_AW-1:0] HIGH_BASE  = 16'hA000,
    parameter logic [CPU_AW-1:0] HIGH_END   = 16'hC000,
    parameter int NARROW_FIRST = 4,
    parameter int HIGH_FIRST   = 6
) (
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rnw,
    input  logic        acc_strobe,
    input  logic [2:0]  bank_sel,
    output logic        rom_ce_n,
    output logic [2:0]  rom_hi,
    output logic        ram_ce_n,
    output logic [14:0] ram_addr,
    output logic        mem_oe_n,
    output logic        ram_we_n
);

    logic     ram_hit;
    logic     rom_sel;
    dev_sel_t sel;

    bdec_window #(
        .ROM_FLOOR(ROM_FLOOR), .WIDE_END(WIDE_END), .NARROW_END(NARROW_END),
        .HIGH_BASE(HIGH_BASE), .HIGH_END(HIGH_END),
        .NARROW_FIRST(NARROW_FIRST), .HIGH_FIRST(HIGH_FIRST)
    ) u_window (
        .addr(cpu_addr), .bank(bank_sel), .ram_hit(ram_hit), .ram_off(ram_addr)
    );

    bdec_rom_map #(.ROM_FLOOR(ROM_FLOOR)) u_rom_map (
        .addr(cpu_addr), .rnw(cpu_rnw), .ram_hit(ram_hit), .bank(bank_sel),
        .rom_sel(rom_sel), .rom_hi(rom_hi)
    );

    assign sel.rom = rom_sel;
    assign sel.ram = ram_hit;

    bdec_strobe u_strobe (
        .rnw(cpu_rnw), .stb(acc_strobe), .sel(sel),
        .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n), .oe_n(mem_oe_n), .we_n(ram_we_n)
    );

    always_comb begin
        if (!$isunknown({cpu_addr, cpu_rnw, rom_ce_n, ram_ce_n})) begin
            assert_ce_excl_R5 : assert (rom_ce_n || ram_ce_n)
                else $error("ROM and SRAM selected together");
            assert_floor_R1 : assert ((cpu_addr >= ROM_FLOOR) || (rom_ce_n && ram_ce_n))
                else $error("device selected below floor");
            assert_no_rom_write_R8 : assert (cpu_rnw || rom_ce_n)
                else $error("ROM enabled on write");
        end
    end

endmodule

// File: tb/bdec_top_bench.sv
module bdec_top_bench;

    logic        clk = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rnw = 1'b1;
    logic        acc_strobe = 1'b0;
    logic [2:0]  bank_sel = '0;
    logic        rom_ce_n, ram_ce_n, mem_oe_n, ram_we_n;
    logic [2:0]  rom_hi;
    logic [14:0] ram_addr;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    bdec_top u_bdec_top (
        .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw), .acc_strobe(acc_strobe),
        .bank_sel(bank_sel), .rom_ce_n(rom_ce_n), .rom_hi(rom_hi),
        .ram_ce_n(ram_ce_n), .ram_addr(ram_addr), .mem_oe_n(mem_oe_n),
        .ram_we_n(ram_we_n)
    );

    // addr, rnw, strobe, bank, exp rom_ce_n, ram_ce_n, oe_n, we_n, ram_addr
    localparam int NV = 16;
    localparam logic [39:0] VEC [NV] = '{
        {16'h1FFF, 1'b1, 1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 15'h0000},
        {16'h2000, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 15'h0000},
        {16'h9FFF, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 15'h7FFF},
        {16'hA000, 1'b1, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b1, 15'h0000},
        {16'h7FFF, 1'b1, 1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 15'h5FFF},
        {16'h8000, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 15'h0000},
        {16'h9FFF, 1'b1, 1'b1, 3'd6, 1'b0, 1'b1, 1'b0, 1'b1, 15'h0000},
        {16'hA000, 1'b0, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 15'h0000},
        {16'hBFFF, 1'b1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 15'h1FFF},
        {16'hC000, 1'b1, 1'b1, 3'd7, 1'b0, 1'b1, 1'b0, 1'b1, 15'h0000},
        {16'hE000, 1'b0, 1'b1, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 15'h0000},
        {16'h3000, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 15'h1000},
        {16'h4000, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 15'h2000},
        {16'hFFFC, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 15'h0000},
        {16'h0000, 1'b0, 1'b1, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 15'h0000},
        {16'h2000, 1'b1, 1'b1, 3'd6, 1'b0, 1'b1, 1'b0, 1'b1, 15'h0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h (addr %h bank %0d rnw %b stb %b)",
                     req, act, exp, cpu_addr, bank_sel, cpu_rnw, acc_strobe);
        end
    endtask

    // independent model of the window rules for read sweeps
    function automatic logic model_ram(input logic [15:0] a, input logic [2:0] b);
        if (b < 3'd4) return (a >= 16'h2000) && (a < 16'hA000);
        if (b < 3'd6) return (a >= 16'h2000) && (a < 16'h8000);
        return (a >= 16'hA000) && (a < 16'hC000);
    endfunction

    task automatic apply(input logic [15:0] a, input logic rnw, input logic stb, input logic [2:0] b);
        @(posedge clk);
        cpu_addr = a; cpu_rnw = rnw; acc_strobe = stb; bank_sel = b;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // idle state: strobe low, address zero
        @(negedge clk);
        check("R1 idle rom_ce_n", 32'(rom_ce_n), 32'd1);
        check("R1 idle ram_ce_n", 32'(ram_ce_n), 32'd1);
        check("R10 idle mem_oe_n", 32'(mem_oe_n), 32'd1);
        check("R9 idle ram_we_n", 32'(ram_we_n), 32'd1);

        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            apply(v[39:24], v[23], v[22], v[21:19]);
            check("R2/R3/R4/R8 rom_ce_n", 32'(rom_ce_n), 32'(v[18]));
            check("R2/R3/R4/R1 ram_ce_n", 32'(ram_ce_n), 32'(v[17]));
            check("R10 mem_oe_n", 32'(mem_oe_n), 32'(v[16]));
            check("R9 ram_we_n", 32'(ram_we_n), 32'(v[15]));
            check("R6 rom_hi", 32'(rom_hi), 32'(v[21:19]));
            if (!v[17]) check("R7 ram_addr", 32'(ram_addr), 32'(v[14:0]));
        end

        // sweep each bank across every window edge with reads
        for (int b = 0; b < 8; b++) begin
            for (int j = 0; j < 12; j++) begin
                logic [15:0] edges [6];
                logic [15:0] a;
                logic        r;
                edges = '{16'h2000, 16'h8000, 16'hA000, 16'hC000, 16'h1000, 16'hF000};
                a = (j % 2 == 0) ? edges[j/2] : edges[j/2] - 16'd1;
                apply(a, 1'b1, 1'b1, 3'(b));
                r = model_ram(a, 3'(b));
                check(b < 4 ? "R2 sweep ram" : (b < 6 ? "R3 sweep ram" : "R4 sweep ram"),
                      32'(ram_ce_n), 32'(!r));
                check("R1/R4 sweep rom", 32'(rom_ce_n), 32'(r || (a < 16'h2000)));
                check("R5 exclusive", 32'(rom_ce_n | ram_ce_n), 32'd1);
                if (r) check("R7 sweep ram_addr", 32'(ram_addr),
                             32'(a - ((b >= 6) ? 16'hA000 : 16'h2000)) & 32'h7FFF);
            end
        end

        // strobe gating of a write into SRAM, bank 5
        apply(16'h7000, 1'b0, 1'b0, 3'd5);
        check("R9 write no strobe", 32'(ram_we_n), 32'd1);
        apply(16'h7000, 1'b0, 1'b1, 3'd5);
        check("R9 write with strobe", 32'(ram_we_n), 32'd0);
        check("R10 oe off on write", 32'(mem_oe_n), 32'd1);
        // write to ROM-only area of bank 4
        apply(16'h8000, 1'b0, 1'b1, 3'd4);
        check("R8 rom write rom_ce_n", 32'(rom_ce_n), 32'd1);
        check("R8 rom write ram_we_n", 32'(ram_we_n), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule